// File: doc/BRIEF.md
# Burst Read Command Translator

This block sits between a split-transaction read engine, whose requests carry an explicit start address and byte count, and a conventional bus master, whose read commands carry no count. For each accepted request it issues one or more read commands. Each command gets one of three kinds. The kind depends on how far the remaining bytes reach from the current address, measured against the word size and the programmed cache line size.

While a burst runs, the translator counts the bytes that arrive. A target disconnect ends the burst early. If bytes are still owed, a new command goes out from the next unread address, and its kind is worked out again. Arriving data fills a completion buffer of fixed size. When the buffer cannot take another word, the burst is stopped. Fetching resumes only after the requester has returned data and released a whole sector of the buffer.

Top module: `brt_translator`

## Requirements
- R1: A command whose bytes, counted from the byte offset within the current 32-bit word, fit inside that one word (offset + remaining <= 4) has kind 2'b01 (plain read).
- R2: A command spanning more than one word that stays inside one cache line of `cls_words`*4 bytes has kind 2'b10 (line read).
- R3: A command that crosses a cache line boundary has kind 2'b11 (multiple read).
- R4: With `cls_words` = 0, every command spanning more than one word has kind 2'b11. `cls_words` is otherwise a power of two and is read whenever a command is issued.
- R5: During a burst, each accepted beat delivers min(4 - address mod 4, remaining) bytes. After a disconnect with bytes still owed, the next command's address is the first byte not yet received.
- R6: The kind of every reissued command is recomputed from the remaining count and the current address.
- R7: The buffer holds 512 bytes. `rx_ready` is high only during a burst with at least 4 bytes free. When fewer than 4 bytes are free, the burst stops (`xfer_on` low). No command is then issued until at least 128 bytes are free. Each `sector_free` pulse adds 128 free bytes, capped at 512. A beat and a release in the same cycle both take effect.
- R8: `done` is a one-cycle pulse in the cycle after the final beat. A zero-count request produces the pulse in the cycle after it is accepted. `busy` is high from the cycle after a non-zero request is accepted until `done`.
- R9: `req_ready` is high only when idle. `rx_valid` and `disc` outside a burst have no effect.
- R10: `cmd_valid` holds with a stable address and kind until `cmd_ready` is sampled high. The burst starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cls_words | input | CLS_W | Cache line size in 32-bit words (0 = no line) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | ADDR_W | Request start byte address |
| req_bytes | input | CNT_W | Request byte count |
| cmd_valid | output | 1 | Read command pending |
| cmd_ready | input | 1 | Bus master takes the command |
| cmd_addr | output | ADDR_W | Command start address |
| cmd_kind | output | 2 | 01 plain, 10 line, 11 multiple |
| rx_valid | input | 1 | A data word arrives on the bus |
| rx_ready | output | 1 | Word is taken this cycle |
| disc | input | 1 | Target disconnect ends the burst |
| xfer_on | output | 1 | Burst in progress |
| sector_free | input | 1 | Requester releases one 128-byte sector |
| busy | output | 1 | Request in progress |
| done | output | 1 | All bytes of the request received |

## Verification
Two pairs of events can land on the same clock edge. A received beat can coincide with a sector release. A disconnect can coincide with the beat that delivers the last owed bytes. The bench provokes the first by pacing releases slowly, so the buffer fills and refills while beats keep arriving. It provokes the second by asserting a disconnect on every cycle of some runs. A behavioural model computes the free space, the next state and the next address from both inputs together. Each clock is compared against it, so an extra or wrong reissue, a lost release or a missed `done` shows up as a mismatch.

// File: rtl/brt_pkg.sv
package brt_pkg;

    typedef enum logic [1:0] {
        RK_NONE  = 2'b00,
        RK_WORD  = 2'b01,
        RK_LINE  = 2'b10,
        RK_MULTI = 2'b11
    } rd_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_XFER,
        SQ_HOLD
    } seq_state_e;

    typedef struct packed {
        logic       take;
        logic [2:0] len;
    } beat_t;

    // Command kind from the current position and the bytes still owed.
    function automatic rd_kind_e pick_kind(input logic [31:0] addr,
                                           input logic [31:0] rem,
                                           input logic [31:0] cls_words);
        logic [31:0] line_b;
        logic [31:0] line_off;
        if ({30'd0, addr[1:0]} + rem <= 32'd4)
            return RK_WORD;
        if (cls_words == 32'd0)
            return RK_MULTI;
        line_b   = cls_words << 2;
        line_off = addr & (line_b - 32'd1);
        return (line_off + rem <= line_b) ? RK_LINE : RK_MULTI;
    endfunction

    // Bytes carried by one word beat starting at the given offset.
    function automatic logic [2:0] beat_len(input logic [1:0] off,
                                            input logic [31:0] rem);
        logic [2:0] room;
        room = 3'd4 - {1'b0, off};
        if (rem < {29'd0, room})
            return rem[2:0];
        return room;
    endfunction

endpackage

// File: rtl/brt_classify.sv
module brt_classify
    import brt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13,
    parameter int CLS_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  rem,
    input  logic [CLS_W-1:0]  cls_words,
    output rd_kind_e          kind
);
    always_comb begin
        kind = pick_kind(32'(addr), 32'(rem), 32'(cls_words));
    end
endmodule

// File: rtl/brt_credit.sv
module brt_credit
    import brt_pkg::*;
#(
    parameter int BUF_BYTES    = 512,
    parameter int SECTOR_BYTES = 128,
    parameter int FREE_W       = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  beat_t             beat,
    input  logic              give,
    output logic [FREE_W-1:0] free,
    output logic              word_ok,
    output logic              word_ok_nx,
    output logic              sector_ok_nx
);
    localparam int SUM_W = FREE_W + 1;

    logic [SUM_W-1:0] sum;
    logic [FREE_W-1:0] free_nx;

    always_comb begin
        sum = {1'b0, free};
        if (beat.take)
            sum = sum - SUM_W'(beat.len);
        if (give)
            sum = sum + SUM_W'(SECTOR_BYTES);
        if (sum > SUM_W'(BUF_BYTES))
            free_nx = FREE_W'(BUF_BYTES);
        else
            free_nx = sum[FREE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            free <= FREE_W'(BUF_BYTES);
        else
            free <= free_nx;
    end

    assign word_ok      = free >= FREE_W'(4);
    assign word_ok_nx   = free_nx >= FREE_W'(4);
    assign sector_ok_nx = free_nx >= FREE_W'(SECTOR_BYTES);
endmodule

// File: rtl/brt_seq.sv
module brt_seq
    import brt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    output logic              req_ready,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              disc,
    input  logic              word_ok,
    input  logic              word_ok_nx,
    input  logic              sector_ok_nx,
    output beat_t             beat,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_rem,
    output logic              xfer_on,
    output logic              busy,
    output logic              done
);
    seq_state_e state;
    logic       last;

    assign req_ready = state == SQ_IDLE;
    assign cmd_valid = state == SQ_ISSUE;
    assign xfer_on   = state == SQ_XFER;
    assign busy      = state != SQ_IDLE;
    assign rx_ready  = xfer_on && word_ok;

    always_comb begin
        beat.take = rx_valid && rx_ready;
        beat.len  = beat_len(cur_addr[1:0], 32'(cur_rem));
        last      = beat.take && (cur_rem == CNT_W'(beat.len));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            cur_addr <= '0;
            cur_rem  <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        if (req_bytes == '0) begin
                            done <= 1'b1;
                        end else begin
                            cur_addr <= req_addr;
                            cur_rem  <= req_bytes;
                            state    <= word_ok_nx ? SQ_ISSUE : SQ_HOLD;
                        end
                    end
                end
                SQ_ISSUE: begin
                    if (cmd_ready)
                        state <= SQ_XFER;
                end
                SQ_XFER: begin
                    if (beat.take) begin
                        cur_addr <= cur_addr + ADDR_W'(beat.len);
                        cur_rem  <= cur_rem - CNT_W'(beat.len);
                    end
                    if (last) begin
                        state <= SQ_IDLE;
                        done  <= 1'b1;
                    end else if (disc) begin
                        state <= word_ok_nx ? SQ_ISSUE : SQ_HOLD;
                    end else if (!word_ok_nx) begin
                        state <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (sector_ok_nx)
                        state <= SQ_ISSUE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/brt_translator.sv
module brt_translator
    import brt_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int CNT_W        = 13,
    parameter int CLS_W        = 8,
    parameter int BUF_SECTORS  = 4,
    parameter int SECTOR_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CLS_W-1:0]  cls_words,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_bytes,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [1:0]        cmd_kind,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic              disc,
    output logic              xfer_on,
    input  logic              sector_free,
    output logic              busy,
    output logic              done
);
    localparam int BUF_BYTES = BUF_SECTORS * SECTOR_BYTES;
    localparam int FREE_W    = $clog2(BUF_BYTES + SECTOR_BYTES + 1);

    beat_t             beat;
    logic [ADDR_W-1:0] addr_w;
    logic [CNT_W-1:0]  rem_w;
    logic [FREE_W-1:0] free_w;
    logic              word_ok, word_ok_nx, sector_ok_nx;
    rd_kind_e          kind_w;

    brt_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_bytes(req_bytes),
        .req_ready(req_ready),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .disc(disc),
        .word_ok(word_ok), .word_ok_nx(word_ok_nx), .sector_ok_nx(sector_ok_nx),
        .beat(beat), .cur_addr(addr_w), .cur_rem(rem_w),
        .xfer_on(xfer_on), .busy(busy), .done(done)
    );

    brt_credit #(.BUF_BYTES(BUF_BYTES), .SECTOR_BYTES(SECTOR_BYTES),
                 .FREE_W(FREE_W)) u_credit (
        .clk(clk), .rst(rst), .beat(beat), .give(sector_free),
        .free(free_w), .word_ok(word_ok), .word_ok_nx(word_ok_nx),
        .sector_ok_nx(sector_ok_nx)
    );

    brt_classify #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CLS_W(CLS_W)) u_cls (
        .addr(addr_w), .rem(rem_w), .cls_words(cls_words), .kind(kind_w)
    );

    assign cmd_addr = addr_w;
    assign cmd_kind = cmd_valid ? kind_w : RK_NONE;
endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 13,
    parameter int FREE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              busy,
    input logic              done,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [1:0]        cmd_kind,
    input logic              rx_ready,
    input logic              xfer_on,
    input logic [CNT_W-1:0]  rem,
    input logic [FREE_W-1:0] free
);
    p_cmd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_kind));

    p_cmd_then_burst_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> xfer_on);

    p_ready_idle_r9: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !busy);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);

    p_rx_room_r7: assert property (@(posedge clk) disable iff (rst)
        rx_ready |-> xfer_on && (free >= FREE_W'(4)));

    p_word_kind_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (32'(cmd_addr[1:0]) + 32'(rem) <= 32'd4) |-> cmd_kind == 2'b01);

    p_cmd_busy_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy && !xfer_on && (rem != '0));
endmodule

bind brt_translator brt_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FREE_W(FREE_W)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .busy(busy), .done(done),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_kind(cmd_kind), .rx_ready(rx_ready), .xfer_on(xfer_on),
    .rem(rem_w), .free(free_w)
);

// File: tb/brt_translator_tb.sv
module brt_translator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUF = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cls_words = 8'd8;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [12:0] req_bytes = '0;
    logic        cmd_valid, cmd_ready;
    logic [31:0] cmd_addr;
    logic [1:0]  cmd_kind;
    logic        rx_valid, rx_ready, disc, xfer_on, sector_free, busy, done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // stimulus knobs
    int stall = 0, rx_gap = 0, disc_every = 0, free_gap = 1, free_after = 0;

    // behavioural model: 0 idle, 1 issue, 2 burst, 3 hold
    int          m_st = 0;
    int unsigned m_addr = 0;
    int          m_rem = 0, m_free = BUF;
    bit          m_done = 0, m_first = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brt_translator u_dut (
        .clk(clk), .rst(rst), .cls_words(cls_words),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_bytes(req_bytes), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_kind(cmd_kind), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .disc(disc), .xfer_on(xfer_on),
        .sector_free(sector_free), .busy(busy), .done(done)
    );

    function automatic int exp_kind(int unsigned a, int unsigned n, int unsigned c);
        int unsigned lb;
        if (a / 4 == (a + n - 1) / 4) return 1;
        if (c == 0) return 3;
        lb = c * 4;
        return (a / lb == (a + n - 1) / lb) ? 2 : 3;
    endfunction

    function automatic string kind_tag(int k);
        if (!m_first) return "R6";
        if (k == 1) return "R1";
        if (k == 2) return "R2";
        return (cls_words == 0) ? "R4" : "R3";
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", tag, what, cyc, act, exp);
        end
    endtask

    // model update
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) begin
            m_st = 0; m_free = BUF; m_done = 0; m_rem = 0; m_first = 0;
        end else begin
            bit beat;
            int blen, nf;
            beat = (m_st == 2) && rx_valid && (m_free >= 4);
            blen = 4 - int'(m_addr % 4);
            if (m_rem < blen) blen = m_rem;
            nf = m_free - (beat ? blen : 0) + (sector_free ? 128 : 0);
            if (nf > BUF) nf = BUF;
            m_done = 0;
            case (m_st)
                0: if (req_valid) begin
                    if (req_bytes == 0) m_done = 1;
                    else begin
                        m_addr = req_addr; m_rem = int'(req_bytes); m_first = 1;
                        m_st = (nf >= 4) ? 1 : 3;
                    end
                end
                1: if (cmd_ready) begin m_st = 2; m_first = 0; end
                2: begin
                    if (beat) begin m_addr += blen; m_rem -= blen; end
                    if (beat && m_rem == 0) begin m_st = 0; m_done = 1; end
                    else if (disc) m_st = (nf >= 4) ? 1 : 3;
                    else if (nf < 4) m_st = 3;
                end
                default: if (nf >= 128) m_st = 1;
            endcase
            m_free = nf;
        end
    end

    // compare and drive away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            cmp("R9", "req_ready", req_ready, m_st == 0);
            cmp("R8", "busy", busy, m_st != 0);
            cmp("R8", "done", done, m_done);
            cmp(m_st == 3 ? "R7" : "R10", "cmd_valid", cmd_valid, m_st == 1);
            cmp("R7", "rx_ready", rx_ready, (m_st == 2) && (m_free >= 4));
            cmp("R7", "xfer_on", xfer_on, m_st == 2);
            if (m_st == 1) begin
                cmp("R5", "cmd_addr", int'(cmd_addr), int'(m_addr));
                cmp(kind_tag(exp_kind(m_addr, m_rem, cls_words)), "cmd_kind",
                    cmd_kind, exp_kind(m_addr, m_rem, cls_words));
            end
        end
        cmd_ready   <= (stall == 0) || (cyc % (stall + 1) == 0);
        rx_valid    <= (rx_gap == 0) || (cyc % 4 != 3);
        disc        <= (disc_every != 0) && (cyc % disc_every == 0);
        sector_free <= (cyc >= free_after) && (free_gap != 0) &&
                       (cyc % free_gap == 0) && (m_free < BUF);
    end

    task automatic run_req(int unsigned a, int n, int c, int st, int gap, int de, int fg, int fdelay);
        @(negedge clk);
        cls_words = 8'(c); stall = st; rx_gap = gap; disc_every = de;
        free_gap = fg; free_after = cyc + fdelay;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_bytes = 13'(n);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 20000 && m_st != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        cmd_ready = 1'b0; rx_valid = 1'b0; disc = 1'b0; sector_free = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R9, R8)
        cmp("R9", "reset req_ready", req_ready, 1);
        cmp("R8", "reset busy", busy, 0);
        // single word and edge of word (R1)
        run_req(32'h100, 4, 8, 0, 0, 0, 1, 0);
        run_req(32'h101, 3, 8, 0, 0, 0, 1, 0);
        run_req(32'h202, 2, 0, 0, 0, 0, 1, 0);
        // inside one line (R2), exact full line
        run_req(32'h103, 2, 8, 0, 0, 0, 1, 0);
        run_req(32'h104, 16, 8, 1, 0, 0, 1, 0);
        run_req(32'h100, 32, 8, 0, 1, 0, 1, 0);
        // line crossing (R3) and no line (R4)
        run_req(32'h11C, 8, 8, 0, 0, 0, 1, 0);
        run_req(32'h200, 8, 0, 0, 0, 0, 1, 0);
        // zero count (R8)
        run_req(32'h20, 0, 8, 0, 0, 0, 1, 0);
        // disconnects with reissue and recomputed kinds (R5, R6), slow releases (R7)
        run_req(32'h1001, 1000, 16, 0, 1, 5, 40, 0);
        // buffer fills and waits for releases (R7)
        run_req(32'h3000, 900, 8, 0, 0, 0, 1, 250);
        // disconnect every cycle, command stalls, small lines (R5, R6, R10)
        run_req(32'h7E, 70, 4, 2, 0, 1, 3, 0);
        // releases racing beats with ragged arrival (R7)
        run_req(32'h5003, 600, 32, 1, 1, 7, 25, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected idle", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule